// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block collects the four level-sensitive interrupt pins (INTA..INTD, numbered 0..3) of a set of PCI devices, each device tagged with the slot number it sits in, and folds them onto four shared interrupt lines. Three fixed slots always land on one particular line, whatever pin they raise. A group of four consecutive slots has its pins rotated so that their interrupts spread evenly across the lines. Every other slot keeps its pin number as its line number. The level of a line is the OR of every device pin that maps onto it.

Each line has a routing byte set by software. The byte names one of sixteen interrupt controller inputs, or parks the line when it holds 16 or more. Each controller input carries the OR of every line routed to it, registered once before it leaves the block. The block also holds an interrupt cause register and three mask registers behind a small word-wide register port. The interrupt controller itself lies outside the block.

Top module: `ir_router`

## Requirements
- R1: A device in slot 10 drives line 3, slot 11 drives line 2's neighbour line 1, and slot 12 drives line 2, whichever of its four pins is asserted.
- R2: A device in slot 18, 19, 20 or 21 asserting pin p drives line ((slot - 18) + p) mod 4.
- R3: A device in any slot other than 10, 11, 12 and 18..21 drives the line whose number equals its pin number.
- R4: A routing byte of value k below 16 sends its line to controller output bit k (irq_out[k]).
- R5: A routing byte of 16 or more leaves its line unconnected, so that line sets no irq_out bit.
- R6: Each irq_out bit is the OR of all lines routed to it, and each line is the OR of all device pins mapped onto it.
- R7: irq_out is registered: a change of pins or routing shows on irq_out after the next rising clock edge and not before.
- R8: A write to the cause register clears bit i (i from 1 to 31) where the written bit i is 0 and keeps the others; no write sets a bit. After every write, bit 0 equals the OR of bits 31:1.
- R9: The CPU mask register keeps only the bits in 0x3C3FFFFE, the PCI mask register only those in 0x03FFFFFE, and the error mask only bits 5:0; other written bits read as 0.
- R10: After reset each routing byte reads 0x80, the cause and all mask registers read 0, and irq_out is 0.
- R11: Register map by reg_addr: 0 holds the four routing bytes (line l in bits 8l+7:8l), 1 the cause register, 2 the CPU mask, 3 the PCI mask, 4 the error mask; any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_slot | input | NUM_DEV*SLOT_W | Slot number of each device, device d in bits d*SLOT_W upward |
| dev_pins | input | NUM_DEV*4 | Interrupt pin levels, device d in bits 4d+3:4d, bit 0 = first pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_out | output | 16 | Registered interrupt controller inputs |

## Verification
A wrong slot table or rotation shows as the wrong irq_out bit one clock after a pin rises, and only when the routing bytes of the lines involved differ, so the routes are set to distinct values for lines 0, 1 and 3 while lines 1 and 2 share one output to expose the OR. A corrupt routing byte either moves the interrupt to another bit or silences it, visible on the next edge and on a read of address 0. Faults in the cause or mask registers stay hidden from irq_out and appear only on a register read right after the write.

// File: rtl/ir_pkg.sv
package ir_pkg;
    localparam int LINES       = 4;
    localparam int PINS        = 4;
    localparam int CTRL_INPUTS = 16;
    localparam int RB_W        = 8;
    localparam int DATA_W      = 32;
    localparam int REG_ADDR_W  = 3;

    typedef logic [RB_W-1:0] route_t;
    localparam route_t ROUTE_RESET = 8'h80;
    localparam route_t ROUTE_LIMIT = route_t'(CTRL_INPUTS);

    localparam logic [DATA_W-1:0] CMASK_KEEP = 32'h3C3F_FFFE;
    localparam logic [DATA_W-1:0] PMASK_KEEP = 32'h03FF_FFFE;
    localparam logic [DATA_W-1:0] EMASK_KEEP = 32'h0000_003F;

    localparam logic [REG_ADDR_W-1:0] A_ROUTE = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_CAUSE = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_CMASK = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_PMASK = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_EMASK = 3'd4;

    // Slot/pin to shared line
    function automatic logic [1:0] slot_to_line(input logic [7:0] slot, input logic [1:0] pin);
        logic [1:0] res;
        if (slot == 8'd10)                       res = 2'd3;
        else if (slot == 8'd11)                  res = 2'd1;
        else if (slot == 8'd12)                  res = 2'd2;
        else if (slot >= 8'd18 && slot <= 8'd21) res = slot[1:0] - 2'd2 + pin;
        else                                     res = pin;
        return res;
    endfunction
endpackage

// File: rtl/ir_swizzle.sv
module ir_swizzle
    import ir_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int SLOT_W  = 5
) (
    input  logic [NUM_DEV*SLOT_W-1:0] dev_slot,
    input  logic [NUM_DEV*PINS-1:0]   dev_pins,
    output logic [LINES-1:0]          line_lvl
);
    always_comb begin
        line_lvl = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            for (int p = 0; p < PINS; p++) begin
                if (dev_pins[d*PINS+p])
                    line_lvl[slot_to_line(8'(dev_slot[d*SLOT_W +: SLOT_W]), 2'(p))] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ir_route.sv
module ir_route
    import ir_pkg::*;
(
    input  logic [LINES-1:0]         line_lvl,
    input  route_t [LINES-1:0]       route,
    output logic [CTRL_INPUTS-1:0]   ctrl_d
);
    always_comb begin
        ctrl_d = '0;
        for (int k = 0; k < CTRL_INPUTS; k++) begin
            for (int l = 0; l < LINES; l++) begin
                if (route[l] == route_t'(k))
                    ctrl_d[k] = ctrl_d[k] | line_lvl[l];
            end
        end
    end
endmodule

// File: rtl/ir_regs.sv
module ir_regs
    import ir_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output route_t [LINES-1:0]    route
);
    typedef struct packed {
        route_t [LINES-1:0] route;
        logic [DATA_W-1:0]  cause;
        logic [DATA_W-1:0]  cmask;
        logic [DATA_W-1:0]  pmask;
        logic [DATA_W-1:0]  emask;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            unique case (reg_addr)
                A_ROUTE: st_d.route = reg_wdata;
                A_CAUSE: begin
                    st_d.cause[DATA_W-1:1] = st_q.cause[DATA_W-1:1] & reg_wdata[DATA_W-1:1];
                    st_d.cause[0]          = |st_d.cause[DATA_W-1:1];
                end
                A_CMASK: st_d.cmask = reg_wdata & CMASK_KEEP;
                A_PMASK: st_d.pmask = reg_wdata & PMASK_KEEP;
                A_EMASK: st_d.emask = reg_wdata & EMASK_KEEP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.route <= {LINES{ROUTE_RESET}};
            st_q.cause <= '0;
            st_q.cmask <= '0;
            st_q.pmask <= '0;
            st_q.emask <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_ROUTE: reg_rdata = st_q.route;
            A_CAUSE: reg_rdata = st_q.cause;
            A_CMASK: reg_rdata = st_q.cmask;
            A_PMASK: reg_rdata = st_q.pmask;
            A_EMASK: reg_rdata = st_q.emask;
            default: reg_rdata = '0;
        endcase
    end

    assign route = st_q.route;

    AST_CAUSE_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cause[0] == |st_q.cause[DATA_W-1:1]); // R8
    AST_CAUSE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.cause & ~$past(st_q.cause)) == '0); // R8
    AST_MASK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cmask & ~CMASK_KEEP) == '0) && ((st_q.pmask & ~PMASK_KEEP) == '0)
        && ((st_q.emask & ~EMASK_KEEP) == '0)); // R9
endmodule

// File: rtl/ir_router.sv
module ir_router
    import ir_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int SLOT_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_DEV*SLOT_W-1:0] dev_slot,
    input  logic [NUM_DEV*PINS-1:0]   dev_pins,
    input  logic                      reg_we,
    input  logic [REG_ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [CTRL_INPUTS-1:0]    irq_out
);
    typedef struct packed {
        logic [CTRL_INPUTS-1:0] irq;
    } out_t;

    logic [LINES-1:0]       line_lvl;
    route_t [LINES-1:0]     route_w;
    logic [CTRL_INPUTS-1:0] ctrl_w;
    out_t                   out_d, out_q;

    ir_swizzle #(.NUM_DEV(NUM_DEV), .SLOT_W(SLOT_W)) u_swz (
        .dev_slot (dev_slot),
        .dev_pins (dev_pins),
        .line_lvl (line_lvl)
    );

    ir_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .route     (route_w)
    );

    ir_route u_route (
        .line_lvl (line_lvl),
        .route    (route_w),
        .ctrl_d   (ctrl_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = ctrl_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_out = out_q.irq;

    AST_QUIET_WHEN_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_lvl == '0) |=> (irq_out == '0)); // R6
    AST_IRQ_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(irq_out) <= LINES)); // R6

    for (genvar l = 0; l < LINES; l++) begin : g_line_chk
        AST_ROUTED_LINE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
            (line_lvl[l] && route_w[l] < ROUTE_LIMIT) |=> irq_out[$past(route_w[l][3:0])]); // R4
    end
endmodule

// File: tb/tb_ir_router.sv
module tb_ir_router;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEV    = 4;
    localparam int SLOT_W     = 5;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NUM_DEV*SLOT_W-1:0] dev_slot = '0;
    logic [NUM_DEV*4-1:0]      dev_pins = '0;
    logic                      reg_we = 1'b0;
    logic [2:0]                reg_addr = '0;
    logic [31:0]               reg_wdata = '0;
    logic [31:0]               reg_rdata;
    logic [15:0]               irq_out;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_route [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_router #(.NUM_DEV(NUM_DEV), .SLOT_W(SLOT_W)) dut (
        .clk(clk), .rst_n(rst_n), .dev_slot(dev_slot), .dev_pins(dev_pins),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int model_line(input int s, input int p);
        if (s == 10) return 3;
        if (s == 11) return 1;
        if (s == 12) return 2;
        if (s >= 18 && s <= 21) return ((s - 18) + p) % 4;
        return p;
    endfunction

    function automatic logic [15:0] model_irq();
        logic [3:0]  lines = '0;
        logic [15:0] res = '0;
        for (int d = 0; d < NUM_DEV; d++)
            for (int p = 0; p < 4; p++)
                if (dev_pins[d*4+p]) lines[model_line(int'(dev_slot[d*SLOT_W +: SLOT_W]), p)] = 1'b1;
        for (int l = 0; l < 4; l++)
            if (lines[l] && m_route[l] < 8'd16) res[m_route[l][3:0]] = 1'b1;
        return res;
    endfunction

    task automatic set_dev(input int d, input int s, input logic [3:0] p);
        dev_slot[d*SLOT_W +: SLOT_W] = SLOT_W'(s);
        dev_pins[d*4 +: 4] = p;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        settle();
        reg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_routes(input logic [7:0] r0, input logic [7:0] r1,
                              input logic [7:0] r2, input logic [7:0] r3);
        m_route[0] = r0; m_route[1] = r1; m_route[2] = r2; m_route[3] = r3;
        write_reg(3'd0, {r3, r2, r1, r0});
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R10 irq_out after reset", 32'(irq_out), 32'h0);
        read_reg(3'd0, v); check("R10 route reset", v, 32'h8080_8080);
        read_reg(3'd1, v); check("R10 cause reset", v, 32'h0);
        read_reg(3'd2, v); check("R10 cpu mask reset", v, 32'h0);
        read_reg(3'd3, v); check("R10 pci mask reset", v, 32'h0);
        read_reg(3'd4, v); check("R10 err mask reset", v, 32'h0);
        read_reg(3'd6, v); check("R11 unused address reads 0", v, 32'h0);
    endtask

    task automatic t_parked_default();
        set_dev(0, 5, 4'hF); set_dev(1, 10, 4'h1);
        settle(); settle();
        check("R5 lines parked at 0x80", 32'(irq_out), 32'h0);
        set_dev(0, 0, 4'h0); set_dev(1, 0, 4'h0);
        settle();
    endtask

    task automatic t_select_each_input();
        for (int k = 0; k < 16; k++) begin
            set_routes(8'(k), 8'h80, 8'h80, 8'h80);
            set_dev(0, 5, 4'h1);
            settle();
            check($sformatf("R4 route %0d", k), 32'(irq_out), 32'(16'h1 << k));
            set_dev(0, 5, 4'h0);
            settle();
        end
    endtask

    task automatic t_fixed_slots();
        set_routes(8'd0, 8'd4, 8'd7, 8'd9);
        for (int s = 10; s <= 12; s++)
            for (int p = 0; p < 4; p++) begin
                set_dev(0, s, 4'(1 << p));
                settle();
                check($sformatf("R1 slot %0d pin %0d", s, p), 32'(irq_out), 32'(model_irq()));
            end
        set_dev(0, 0, 4'h0); settle();
    endtask

    task automatic t_rotation();
        for (int s = 18; s <= 21; s++)
            for (int p = 0; p < 4; p++) begin
                set_dev(1, s, 4'(1 << p));
                settle();
                check($sformatf("R2 slot %0d pin %0d", s, p), 32'(irq_out), 32'(model_irq()));
            end
        set_dev(1, 0, 4'h0); settle();
    endtask

    task automatic t_passthrough();
        int slots[4] = '{0, 13, 17, 31};
        foreach (slots[i])
            for (int p = 0; p < 4; p++) begin
                set_dev(2, slots[i], 4'(1 << p));
                settle();
                check($sformatf("R3 slot %0d pin %0d", slots[i], p), 32'(irq_out), 32'(model_irq()));
            end
        set_dev(2, 0, 4'h0); settle();
    endtask

    task automatic t_sharing();
        set_routes(8'd2, 8'd5, 8'd5, 8'd9);
        set_dev(0, 11, 4'h4); set_dev(1, 12, 4'h8); set_dev(2, 10, 4'h2); set_dev(3, 7, 4'h1);
        settle();
        check("R6 all lines, 1 and 2 shared", 32'(irq_out), 32'h0224);
        set_dev(0, 11, 4'h0);
        settle();
        check("R6 shared output held by other line", 32'(irq_out), 32'(model_irq()));
        set_dev(1, 20, 4'h0); set_dev(3, 20, 4'h3);
        settle();
        check("R6 two pins onto shared output", 32'(irq_out), 32'(model_irq()));
        for (int d = 0; d < NUM_DEV; d++) set_dev(d, 0, 4'h0);
        settle();
        check("R6 all released", 32'(irq_out), 32'h0);
    endtask

    task automatic t_disable();
        set_routes(8'hFF, 8'd5, 8'd16, 8'h10);
        set_dev(0, 5, 4'hF);
        settle();
        check("R5 lines with 16 or more unrouted", 32'(irq_out), 32'h0020);
        set_dev(0, 0, 4'h0); settle();
    endtask

    task automatic t_latency();
        set_routes(8'd3, 8'd5, 8'd5, 8'd9);
        set_dev(0, 5, 4'h1);
        #1 check("R7 no change before edge", 32'(irq_out), 32'h0);
        settle();
        check("R7 change after one edge", 32'(irq_out), 32'h0008);
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0905_050C;
        m_route[0] = 8'd12;
        settle();
        reg_we = 1'b0;
        check("R7 route write not yet on output", 32'(irq_out), 32'h0008);
        settle();
        check("R7 new route after next edge", 32'(irq_out), 32'h1000);
        set_dev(0, 0, 4'h0); settle();
    endtask

    task automatic t_regs();
        logic [31:0] v;
        write_reg(3'd2, 32'hFFFF_FFFF); read_reg(3'd2, v); check("R9 cpu mask bits", v, 32'h3C3F_FFFE);
        write_reg(3'd3, 32'hFFFF_FFFF); read_reg(3'd3, v); check("R9 pci mask bits", v, 32'h03FF_FFFE);
        write_reg(3'd4, 32'hFFFF_FFFF); read_reg(3'd4, v); check("R9 err mask bits", v, 32'h0000_003F);
        write_reg(3'd1, 32'hFFFF_FFFF); read_reg(3'd1, v); check("R8 cause not set by ones", v, 32'h0);
        write_reg(3'd1, 32'h0000_0001); read_reg(3'd1, v); check("R8 cause bit0 follows 31:1", v, 32'h0);
        write_reg(3'd7, 32'hFFFF_FFFF);
        read_reg(3'd0, v); check("R11 route untouched by bad address", v, {m_route[3], m_route[2], m_route[1], m_route[0]});
        read_reg(3'd2, v); check("R11 cpu mask untouched", v, 32'h3C3F_FFFE);
        read_reg(3'd7, v); check("R11 bad address reads 0", v, 32'h0);
        write_reg(3'd0, 32'h0A0B_0C0D); read_reg(3'd0, v); check("R11 route byte layout", v, 32'h0A0B_0C0D);
        m_route[0] = 8'h0D; m_route[1] = 8'h0C; m_route[2] = 8'h0B; m_route[3] = 8'h0A;
        set_dev(0, 5, 4'h4);
        settle(); settle();
        check("R11 line 2 byte drives output", 32'(irq_out), 32'h0800);
        set_dev(0, 0, 4'h0); settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int l = 0; l < 4; l++) m_route[l] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parked_default();
        t_select_each_input();
        t_fixed_slots();
        t_rotation();
        t_passthrough();
        t_sharing();
        t_disable();
        t_latency();
        t_regs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule